// File: doc/BRIEF.md
# Fixed-Point to Double-Precision Converter

This block turns a 32-bit fixed-point quantity into an IEEE-754 binary64 value. It receives an instruction word and a 64-bit source operand, decodes which of three conversions the word asks for, and converts the less significant 32-bit half of the source. That half can be read as a two's-complement integer, as a two's-complement fraction (word / 2^31, range -1.0 up to just below 1.0), or as an unsigned fraction (word / 2^32, range 0 up to just below 1.0).

The unit sits in one register stage. A request presented with `in_valid` high is answered on the next rising clock edge, with either `out_valid` and the converted value, or `out_illegal` and a zero result. Every 32-bit input fits in the 52-bit binary64 mantissa, so the result is always exact. The rounding-mode input is accepted for interface compatibility but cannot change any result.

Top module: `fxd2dp_cvt`

## Requirements
- R1: Only `src[31:0]` (bits 32 to 63 in big-endian numbering) is converted; `src[63:32]` has no effect on the result.
- R2: A word is legal only when `instr[31:26]` = 6'b000100 and `instr[20:16]` = 5'b00000 and `instr[10:0]` holds one of the three conversion codes; `instr[25:21]` and `instr[15:11]` (register indices) may take any value. Any other word raises `out_illegal`.
- R3: `instr[10:0]` = 11'b01011110001 converts the word as a signed integer, exactly.
- R4: `instr[10:0]` = 11'b01011110011 converts the word as a signed fraction (word / 2^31), exactly; the magnitude never exceeds 1.0.
- R5: `instr[10:0]` = 11'b01011110010 converts the word as an unsigned fraction (word / 2^32), exactly; the sign bit of the result is always 0.
- R6: A zero input word gives +0.0 (all 64 bits zero) in every mode; no result is ever -0.0 or subnormal.
- R7: `rnd_mode` has no effect on the result for any of its four values.
- R8: An accepted request produces exactly one of `out_valid` or `out_illegal` on the following clock edge; without a request both are low, and both are low after reset.
- R9: Input 0x80000000 gives exactly -1.0 (0xBFF0000000000000) as a signed fraction and exactly -2^31 (0xC1E0000000000000) as a signed integer.
- R10: When `out_illegal` is high, `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe for the current word and operand |
| instr | input | 32 | Instruction word to decode |
| src | input | 64 | Source operand; low half is converted |
| rnd_mode | input | 2 | Rounding mode, accepted but without effect |
| out_valid | output | 1 | Result holds a converted value |
| out_illegal | output | 1 | The last request did not decode |
| result | output | 64 | Binary64 result, zero when not valid |

## Verification
The assertions watch, on every cycle, that the two response flags never coincide and only follow a request, that an illegal response carries a zero result, that unsigned-fraction results are never negative, that fractional results stay within magnitude 1.0, that a zero exponent only appears with an all-zero word, and that the normaliser always places a leading one in the top position. Exact bit patterns for each mode, the extreme value 0x80000000, the indifference to the high source half and to the rounding mode, and the rejection of each malformed field can only be shown by the bench's directed scenarios against its own reference conversion.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int WORD_W = 32;
  localparam int DP_W   = 64;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int BIAS   = 1023;
  localparam int LZ_W   = $clog2(WORD_W) + 1;

  localparam logic [5:0]  PRI_OPC  = 6'b000100;
  localparam logic [10:0] XO_SINT  = 11'b01011110001;
  localparam logic [10:0] XO_UFRAC = 11'b01011110010;
  localparam logic [10:0] XO_SFRAC = 11'b01011110011;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_SINT  = 2'd1,
    OP_UFRAC = 2'd2,
    OP_SFRAC = 2'd3
  } cvt_op_e;

  typedef struct packed {
    logic    legal;
    cvt_op_e op;
  } dec_s;

  // Binary point position below the word's LSB, per mode.
  function automatic int unsigned frac_shift(cvt_op_e op);
    case (op)
      OP_SFRAC: return WORD_W - 1;
      OP_UFRAC: return WORD_W;
      default:  return 0;
    endcase
  endfunction

  function automatic logic is_signed_op(cvt_op_e op);
    return (op == OP_SINT) || (op == OP_SFRAC);
  endfunction

  // Biased exponent from the leading-one position of the magnitude.
  function automatic logic [EXP_W-1:0] dp_exponent(logic [LZ_W-1:0] lz, cvt_op_e op);
    int unsigned msb;
    msb = (WORD_W - 1) - int'(lz);
    return EXP_W'(BIAS + msb - frac_shift(op));
  endfunction
endpackage

// File: rtl/cvt_decode.sv
module cvt_decode
  import cvt_pkg::*;
(
  input  logic [31:0] instr,
  output dec_s        dec
);
  logic        opc_ok;
  logic        pad_ok;
  logic [10:0] xo;

  assign opc_ok = (instr[31:26] == PRI_OPC);
  assign pad_ok = (instr[20:16] == 5'b00000);
  assign xo     = instr[10:0];

  always_comb begin
    dec.op = OP_NONE;
    if (opc_ok && pad_ok) begin
      case (xo)
        XO_SINT:  dec.op = OP_SINT;
        XO_UFRAC: dec.op = OP_UFRAC;
        XO_SFRAC: dec.op = OP_SFRAC;
        default:  dec.op = OP_NONE;
      endcase
    end
    dec.legal = (dec.op != OP_NONE);
  end
endmodule

// File: rtl/cvt_lzc.sv
module cvt_lzc #(
  parameter int W    = 32,
  parameter int CW   = $clog2(W) + 1
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] lz,
  output logic          all_zero
);
  // Scan upward; the highest set bit is the last one to write.
  always_comb begin
    lz = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (val[i]) lz = CW'(W - 1 - i);
    end
  end

  assign all_zero = (val == '0);
endmodule

// File: rtl/cvt_mag.sv
module cvt_mag #(
  parameter int W = 32
) (
  input  logic [W-1:0] word,
  input  logic         signed_in,
  output logic         neg,
  output logic [W-1:0] mag
);
  // The most negative word maps onto 2^(W-1), still representable unsigned.
  assign neg = signed_in & word[W-1];
  assign mag = neg ? (~word + W'(1)) : word;
endmodule

// File: rtl/cvt_pack.sv
module cvt_pack
  import cvt_pkg::*;
(
  input  logic               neg,
  input  logic [WORD_W-1:0]  mag,
  input  logic [LZ_W-1:0]    lz,
  input  logic               zero,
  input  cvt_op_e            op,
  output logic [DP_W-1:0]    dp
);
  logic [WORD_W-1:0] norm;
  logic [FRAC_W-1:0] frac;
  logic [EXP_W-1:0]  expo;

  assign norm = mag << lz;
  assign frac = {norm[WORD_W-2:0], {(FRAC_W-WORD_W+1){1'b0}}};
  assign expo = dp_exponent(lz, op);

  always_comb begin
    dp = zero ? '0 : {neg, expo, frac};
  end

  // Shifter and leading-zero counter must agree on the hidden bit.
  always_comb begin
    if (!zero) begin
      AST_NORM_LEAD: assert (norm[WORD_W-1]); // R3
    end
  end
endmodule

// File: rtl/fxd2dp_cvt.sv
module fxd2dp_cvt
  import cvt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] instr,
  input  logic [63:0] src,
  input  logic [1:0]  rnd_mode,
  output logic        out_valid,
  output logic        out_illegal,
  output logic [63:0] result
);
  dec_s              dec;
  logic              mag_neg;
  logic [WORD_W-1:0] mag;
  logic [LZ_W-1:0]   lz;
  logic              mag_zero;
  logic [DP_W-1:0]   dp;
  cvt_op_e           op_q;
  logic              accept;
  logic              reject;

  // Fields that by definition never reach the datapath.
  logic sig_unused;
  assign sig_unused = ^{src[63:32], rnd_mode, instr[25:21], instr[15:11]};

  cvt_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  cvt_mag #(.W(WORD_W)) u_mag (
    .word      (src[WORD_W-1:0]),
    .signed_in (is_signed_op(dec.op)),
    .neg       (mag_neg),
    .mag       (mag)
  );

  cvt_lzc #(.W(WORD_W), .CW(LZ_W)) u_lzc (
    .val      (mag),
    .lz       (lz),
    .all_zero (mag_zero)
  );

  cvt_pack u_pack (
    .neg  (mag_neg),
    .mag  (mag),
    .lz   (lz),
    .zero (mag_zero),
    .op   (dec.op),
    .dp   (dp)
  );

  assign accept = in_valid &  dec.legal;
  assign reject = in_valid & ~dec.legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      result      <= '0;
      op_q        <= OP_NONE;
    end else begin
      out_valid   <= accept;
      out_illegal <= reject;
      result      <= accept ? dp : '0;
      op_q        <= accept ? dec.op : OP_NONE;
    end
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_illegal)); // R8
  AST_RESP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_illegal) |-> $past(in_valid)); // R8
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (result == '0)); // R10
  AST_UFRAC_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == OP_UFRAC) |-> !result[DP_W-1]); // R5
  AST_FRAC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == OP_SFRAC) |-> (result[DP_W-2 -: EXP_W] <= EXP_W'(BIAS))); // R4
  AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && result[DP_W-2 -: EXP_W] == '0) |-> (result == '0)); // R6
endmodule

// File: tb/sim_fxd2dp_cvt.sv
module sim_fxd2dp_cvt;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr;
  logic [63:0] src;
  logic [1:0]  rnd_mode;
  logic        out_valid;
  logic        out_illegal;
  logic [63:0] result;

  int n_checks;
  int n_errors;
  bit done;

  localparam logic [10:0] C_SI = 11'b01011110001;
  localparam logic [10:0] C_UF = 11'b01011110010;
  localparam logic [10:0] C_SF = 11'b01011110011;

  fxd2dp_cvt u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .src(src),
    .rnd_mode(rnd_mode), .out_valid(out_valid), .out_illegal(out_illegal),
    .result(result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] mk(logic [10:0] xo, logic [4:0] rd, logic [4:0] rb);
    return {6'b000100, rd, 5'b00000, rb, xo};
  endfunction

  // Reference: find the top bit by repeated halving, then place it.
  function automatic logic [63:0] ref_dp(logic [10:0] xo, logic [31:0] w);
    logic [63:0] m;
    logic        s;
    int          top;
    int          off;
    logic [63:0] t;
    logic [10:0] e;
    if (w == 32'd0) return 64'd0;
    s = (xo != C_UF) && w[31];
    m = s ? (64'd4294967296 - {32'd0, w}) : {32'd0, w};
    off = (xo == C_SF) ? 31 : (xo == C_UF) ? 32 : 0;
    t = m; top = -1;
    while (t != 64'd0) begin t = t >> 1; top++; end
    e = 11'(1023 + top - off);
    return {s, e, 52'((m << (52 - top)) & 64'h000F_FFFF_FFFF_FFFF)};
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] iw, logic [63:0] s, logic [1:0] rm);
    @(negedge clk);
    in_valid = 1'b1; instr = iw; src = s; rnd_mode = rm;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic conv(string req, logic [10:0] xo, logic [63:0] s, logic [1:0] rm, logic [63:0] exp);
    issue(mk(xo, 5'd3, 5'd9), s, rm);
    check(req, "valid", {63'd0, out_valid}, 64'd1);
    check(req, "illegal", {63'd0, out_illegal}, 64'd0);
    check(req, "result", result, exp);
  endtask

  task automatic t_reset();
    check("R8", "reset valid", {63'd0, out_valid}, 64'd0);
    check("R8", "reset illegal", {63'd0, out_illegal}, 64'd0);
    check("R8", "reset result", result, 64'd0);
  endtask

  task automatic t_sint();
    conv("R3", C_SI, 64'd1, 2'd0, 64'h3FF0_0000_0000_0000);
    conv("R3", C_SI, 64'h0000_0000_FFFF_FFFF, 2'd0, 64'hBFF0_0000_0000_0000);
    conv("R3", C_SI, 64'h0000_0000_7FFF_FFFF, 2'd0, ref_dp(C_SI, 32'h7FFF_FFFF));
    conv("R3", C_SI, 64'd1000, 2'd0, ref_dp(C_SI, 32'd1000));
    conv("R3", C_SI, 64'h0000_0000_FFFF_FC18, 2'd0, ref_dp(C_SI, 32'hFFFF_FC18));
  endtask

  task automatic t_sfrac();
    conv("R4", C_SF, 64'h0000_0000_4000_0000, 2'd0, 64'h3FE0_0000_0000_0000);
    conv("R4", C_SF, 64'h0000_0000_7FFF_FFFF, 2'd0, ref_dp(C_SF, 32'h7FFF_FFFF));
    conv("R4", C_SF, 64'h0000_0000_C000_0000, 2'd0, 64'hBFE0_0000_0000_0000);
    conv("R4", C_SF, 64'h0000_0000_0000_0001, 2'd0, ref_dp(C_SF, 32'd1));
  endtask

  task automatic t_ufrac();
    conv("R5", C_UF, 64'h0000_0000_8000_0000, 2'd0, 64'h3FE0_0000_0000_0000);
    conv("R5", C_UF, 64'd1, 2'd0, 64'h3DF0_0000_0000_0000);
    conv("R5", C_UF, 64'h0000_0000_FFFF_FFFF, 2'd0, 64'h3FEF_FFFF_FFE0_0000);
    conv("R5", C_UF, 64'h0000_0000_1234_5678, 2'd0, ref_dp(C_UF, 32'h1234_5678));
  endtask

  task automatic t_zero();
    conv("R6", C_SI, 64'd0, 2'd0, 64'd0);
    conv("R6", C_SF, 64'd0, 2'd0, 64'd0);
    conv("R6", C_UF, 64'd0, 2'd0, 64'd0);
  endtask

  task automatic t_round();
    for (int rm = 0; rm < 4; rm++) begin
      conv("R7", C_UF, 64'h0000_0000_ABCD_EF01, 2'(rm), ref_dp(C_UF, 32'hABCD_EF01));
      conv("R7", C_SI, 64'h0000_0000_8765_4321, 2'(rm), ref_dp(C_SI, 32'h8765_4321));
    end
  endtask

  task automatic t_high_word();
    conv("R1", C_SI, 64'hFFFF_FFFF_0000_0005, 2'd0, ref_dp(C_SI, 32'd5));
    conv("R1", C_SF, 64'hDEAD_BEEF_2000_0000, 2'd0, ref_dp(C_SF, 32'h2000_0000));
    conv("R1", C_UF, 64'h8000_0000_0000_0000, 2'd0, 64'd0);
  endtask

  task automatic bad(string what, logic [31:0] iw);
    issue(iw, 64'h0000_0000_1234_5678, 2'd0);
    check("R2", {what, " illegal"}, {63'd0, out_illegal}, 64'd1);
    check("R2", {what, " valid"}, {63'd0, out_valid}, 64'd0);
    check("R10", {what, " result"}, result, 64'd0);
  endtask

  task automatic t_illegal();
    bad("primary", {6'b000101, 5'd1, 5'd0, 5'd2, C_SI});
    bad("pad", {6'b000100, 5'd1, 5'd4, 5'd2, C_SF});
    bad("xo000", {6'b000100, 5'd1, 5'd0, 5'd2, 11'b01011110000});
    bad("xo100", {6'b000100, 5'd1, 5'd0, 5'd2, 11'b01011110100});
    bad("xohi", {6'b000100, 5'd1, 5'd0, 5'd2, 11'b11011110001});
    // register fields are free
    conv("R2", C_UF, 64'h0000_0000_8000_0000, 2'd0, 64'h3FE0_0000_0000_0000);
    issue(mk(C_SI, 5'd31, 5'd31), 64'd2, 2'd0);
    check("R2", "regs any valid", {63'd0, out_valid}, 64'd1);
    check("R2", "regs any result", result, 64'h4000_0000_0000_0000);
  endtask

  task automatic t_min_value();
    conv("R9", C_SF, 64'h0000_0000_8000_0000, 2'd0, 64'hBFF0_0000_0000_0000);
    conv("R9", C_SI, 64'h0000_0000_8000_0000, 2'd0, 64'hC1E0_0000_0000_0000);
  endtask

  task automatic t_idle();
    issue(mk(C_SI, 5'd1, 5'd1), 64'd7, 2'd0);
    @(posedge clk);
    #1;
    check("R8", "idle valid", {63'd0, out_valid}, 64'd0);
    check("R8", "idle illegal", {63'd0, out_illegal}, 64'd0);
  endtask

  initial begin
    n_checks = 0; n_errors = 0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; src = '0; rnd_mode = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_sint();
    t_sfrac();
    t_ufrac();
    t_zero();
    t_round();
    t_high_word();
    t_illegal();
    t_min_value();
    t_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule